// File: doc/BRIEF.md
# Three-Channel Down-Counting Timer with Watchdog

This block is a register-mapped timer peripheral with three 32-bit down-counters. Channels 0 and 1 are general-purpose event timers. Channel 2 is also the watchdog. Software loads each channel through a value register, reads the live count back at any time, and can give the channel a reload value for periodic operation. A single control word sets three things per channel: whether it runs, whether it reloads after expiry or fires only once, and whether it counts on every core clock or only on cycles where the 25 MHz tick-enable is high.

Every expiry raises a per-channel cause bit. The cause bits are combined with a mask to form one interrupt line. A watchdog expiry can also latch a reset request output, but only while a separate enable bit allows it. Once that output is asserted, it stays asserted until the block itself is reset. The register port is a plain synchronous write strobe with a combinational read.

Top module: `tri_timer_wdt`

## Requirements
- R1: The value register of channel n is at byte offset 0x10+8n and its reload register is at 0x14+8n. A write to a value register loads the count. A read of it returns the live count. A read of a reload register returns the last value written to it.
- R2: The control word is at offset 0x00. For channel n, bit 4n is run, bit 4n+1 is reload-after-expiry and bit 4n+2 selects the tick-enable as the count reference. All other control bits read as zero.
- R3: On a count step, a nonzero count decrements by one. A step taken at zero is an expiry. With reload-after-expiry set, the expiry copies the reload value into the count. With it clear, a channel fires once after each value write and then holds at zero without firing again.
- R4: A channel at zero with reload-after-expiry set and a reload value of 0xFFFFFFFF wraps to 0xFFFFFFFF and keeps decrementing.
- R5: Expiry of channel 2 sets the reset output only while bit 0 of the reset-enable register at offset 0x38 is 1.
- R6: With the reference-select bit set, a running channel steps only in cycles where tick_25m is high. Otherwise it steps on every clock.
- R7: Cause bits are at offset 0x30 and mask bits are at offset 0x34, with bit n belonging to channel n. irq is high exactly when some cause bit and its matching mask bit are both 1.
- R8: While a channel's run bit is 0 and no value write targets it, its count holds.
- R9: Writing 0 to a cause bit clears it. Writing 1 to it leaves it unchanged.
- R10: An expiry in the same cycle as a clearing write to the same cause bit leaves that bit set.
- R11: Once asserted, the reset output stays high whatever is written, until rst_n is applied.
- R12: Unlisted offsets read zero and ignore writes. A synchronous reset (rst_n low at a clock edge) zeroes every register, every count and the reset output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the register accessed |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| tick_25m | input | 1 | 25 MHz reference tick-enable, one core cycle wide |
| irq | output | 1 | Interrupt: any unmasked pending cause |
| rst_out | output | 1 | Sticky watchdog reset request |

## Verification
The bench targets these cases:
- **Wrap from zero to an all-ones reload.** A design that compared against one instead of zero, or that took the reload path wrongly, would return a count other than 0xFFFFFFFE two steps later.
- **One-shot re-firing.** A design that kept expiring at zero would set the cause bit again after software cleared it.
- **Expiry colliding with a clear.** A channel with a zero count and a zero reload expires on every step, so a clearing write always lands in an expiry cycle. A design that let the write win would read the cause bit back as zero.
- **Watchdog gating and stickiness.** An ungated watchdog expiry would raise rst_out too early. A non-sticky output would drop when software disables the channel and the enable bit.
- **Reference-select.** A counter that ignored the tick would drift while the tick is held low.

// File: rtl/tmr_pkg.sv
// Shared constants and types for the three-channel timer.
// Assumes byte offsets on an 8-bit address and a 32-bit data path.
package tmr_pkg;
    localparam int AW         = 8;
    localparam int DW         = 32;
    localparam int NCH_DEF    = 3;
    localparam int CNT_W_DEF  = 32;
    localparam int CH_STRIDE  = 8;
    localparam int CTL_STRIDE = 4;
    localparam int CTL_EN     = 0;
    localparam int CTL_AUTO   = 1;
    localparam int CTL_REF    = 2;

    localparam logic [AW-1:0] A_CTRL  = 8'h00;
    localparam logic [AW-1:0] A_VAL0  = 8'h10;
    localparam logic [AW-1:0] A_REL0  = 8'h14;
    localparam logic [AW-1:0] A_CAUSE = 8'h30;
    localparam logic [AW-1:0] A_MASK  = 8'h34;
    localparam logic [AW-1:0] A_RSTEN = 8'h38;

    typedef struct packed {
        logic ref_sel;
        logic auto_rl;
        logic en;
    } chan_cfg_t;
endpackage

// File: rtl/tmr_chan.sv
// One down-counting channel.
// A value write loads the count and arms the one-shot. The write wins over a
// step in the same cycle. A step at zero is an expiry: it reloads in
// auto-reload mode, and otherwise disarms so the channel fires only once.
// Assumes cfg is registered by the parent.
module tmr_chan
    import tmr_pkg::*;
#(
    parameter int CW = CNT_W_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  chan_cfg_t     cfg,
    input  logic          tick,
    input  logic          ld_val,
    input  logic          ld_rel,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] rel,
    output logic          expire
);
    logic armed_q;
    logic step;

    assign step   = cfg.en && (!cfg.ref_sel || tick);
    assign expire = step && !ld_val && (cnt == '0) && (cfg.auto_rl || armed_q);

    // Reload register: written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n)      rel <= '0;
        else if (ld_val == 1'b0 && ld_rel) rel <= wdata;
    end

    // Count and one-shot arm: load, decrement, reload or disarm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            armed_q <= 1'b0;
        end else if (ld_val) begin
            cnt     <= wdata;
            armed_q <= 1'b1;
        end else if (step) begin
            if (cnt != '0)         cnt     <= cnt - 1'b1;
            else if (expire) begin
                if (cfg.auto_rl)   cnt     <= rel;
                else               armed_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tmr_evt.sv
// Cause, mask and watchdog reset-out logic.
// Cause bits collect expiries. A write clears the bits where wbits is 0, and
// a same-cycle expiry keeps its bit set. The reset output latches on a gated
// watchdog expiry and is cleared only by rst_n. The last channel is the
// watchdog.
module tmr_evt #(
    parameter int NCH = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] expire,
    input  logic           wr_cause,
    input  logic           wr_mask,
    input  logic           wr_rsten,
    input  logic [NCH-1:0] wbits,
    input  logic           wbit0,
    output logic [NCH-1:0] cause,
    output logic [NCH-1:0] mask,
    output logic           rsten,
    output logic           irq,
    output logic           rst_out
);
    localparam int WDG = NCH - 1;

    // Cause bits: set by expiry, cleared by writing zero.
    always_ff @(posedge clk) begin
        if (!rst_n)        cause <= '0;
        else if (wr_cause) cause <= (cause & wbits) | expire;
        else               cause <= cause | expire;
    end

    // Interrupt mask and watchdog reset-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask  <= '0;
            rsten <= 1'b0;
        end else begin
            if (wr_mask)  mask  <= wbits;
            if (wr_rsten) rsten <= wbit0;
        end
    end

    // Sticky reset request from a permitted watchdog expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)                      rst_out <= 1'b0;
        else if (expire[WDG] && rsten)   rst_out <= 1'b1;
    end

    assign irq = |(cause & mask);
endmodule

// File: rtl/tri_timer_wdt.sv
// Top of the timer block.
// Decodes register writes, holds the per-channel control fields, builds
// NUM_CH channels and drives the combinational read mux.
// Assumes NUM_CH*4 <= 32 and CW <= 32. The last channel is the watchdog.
module tri_timer_wdt
    import tmr_pkg::*;
#(
    parameter int NUM_CH = NCH_DEF,
    parameter int CW     = CNT_W_DEF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          tick_25m,
    output logic          irq,
    output logic          rst_out
);
    localparam int CTL_W = NUM_CH * CTL_STRIDE;

    logic [NUM_CH-1:0]         en_w, exp_w, cause_w, mask_w;
    logic [NUM_CH-1:0][CW-1:0] cnt_w, rel_w;
    logic [DW-1:0]             ctrl_rd;
    logic                      rsten_w;
    logic                      wr_ctrl, wr_cause, wr_mask, wr_rsten;

    assign wr_ctrl  = wr_en && (addr == A_CTRL);
    assign wr_cause = wr_en && (addr == A_CAUSE);
    assign wr_mask  = wr_en && (addr == A_MASK);
    assign wr_rsten = wr_en && (addr == A_RSTEN);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [AW-1:0] VAL_A = AW'(int'(A_VAL0) + CH_STRIDE * g);
        localparam logic [AW-1:0] REL_A = AW'(int'(A_REL0) + CH_STRIDE * g);
        chan_cfg_t cfg_q;

        // Per-channel control field, written through the shared control word.
        always_ff @(posedge clk) begin
            if (!rst_n)       cfg_q <= '0;
            else if (wr_ctrl) cfg_q <= '{ref_sel: wdata[CTL_STRIDE*g+CTL_REF],
                                         auto_rl: wdata[CTL_STRIDE*g+CTL_AUTO],
                                         en:      wdata[CTL_STRIDE*g+CTL_EN]};
        end

        assign en_w[g] = cfg_q.en;
        assign ctrl_rd[CTL_STRIDE*g +: CTL_STRIDE] =
            {1'b0, cfg_q.ref_sel, cfg_q.auto_rl, cfg_q.en};

        tmr_chan #(.CW(CW)) u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .cfg    (cfg_q),
            .tick   (tick_25m),
            .ld_val (wr_en && (addr == VAL_A)),
            .ld_rel (wr_en && (addr == REL_A)),
            .wdata  (wdata[CW-1:0]),
            .cnt    (cnt_w[g]),
            .rel    (rel_w[g]),
            .expire (exp_w[g])
        );
    end

    if (CTL_W < DW) begin : g_ctl_pad
        assign ctrl_rd[DW-1:CTL_W] = '0;
    end

    tmr_evt #(.NCH(NUM_CH)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .expire   (exp_w),
        .wr_cause (wr_cause),
        .wr_mask  (wr_mask),
        .wr_rsten (wr_rsten),
        .wbits    (wdata[NUM_CH-1:0]),
        .wbit0    (wdata[0]),
        .cause    (cause_w),
        .mask     (mask_w),
        .rsten    (rsten_w),
        .irq      (irq),
        .rst_out  (rst_out)
    );

    // Read mux: mapped registers return data, all other offsets return zero.
    always_comb begin
        rdata = '0;
        if (addr == A_CTRL)  rdata = ctrl_rd;
        if (addr == A_CAUSE) rdata = DW'(cause_w);
        if (addr == A_MASK)  rdata = DW'(mask_w);
        if (addr == A_RSTEN) rdata = DW'(rsten_w);
        for (int n = 0; n < NUM_CH; n++) begin
            if (addr == AW'(int'(A_VAL0) + CH_STRIDE * n)) rdata = DW'(cnt_w[n]);
            if (addr == AW'(int'(A_REL0) + CH_STRIDE * n)) rdata = DW'(rel_w[n]);
        end
    end
endmodule

// File: rtl/tri_timer_wdt_chk.sv
// Property checker for tri_timer_wdt, attached with the bind below.
// It watches the ports and the signals passed between the channels and the
// event logic.
module tri_timer_wdt_chk
    import tmr_pkg::*;
#(
    parameter int NCH = NCH_DEF,
    parameter int CW  = CNT_W_DEF
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [AW-1:0]          addr,
    input logic                   irq,
    input logic                   rst_out,
    input logic                   rsten,
    input logic [NCH-1:0]         en,
    input logic [NCH-1:0]         expire,
    input logic [NCH-1:0]         cause,
    input logic [NCH-1:0]         mask,
    input logic [NCH-1:0][CW-1:0] cnt
);
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out |=> rst_out);

    p_wdg_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_out) |-> $past(expire[NCH-1] && rsten));

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

    p_cause_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (expire == '0 && !(wr_en && addr == A_CAUSE)) |=> $stable(cause));

    for (genvar g = 0; g < NCH; g++) begin : g_pc
        localparam logic [AW-1:0] VAL_A = AW'(int'(A_VAL0) + CH_STRIDE * g);

        p_expiry_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
            expire[g] |=> cause[g]);

        p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!en[g] && !(wr_en && addr == VAL_A)) |=> $stable(cnt[g]));
    end
endmodule

bind tri_timer_wdt tri_timer_wdt_chk #(.NCH(NUM_CH), .CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .irq     (irq),
    .rst_out (rst_out),
    .rsten   (rsten_w),
    .en      (en_w),
    .expire  (exp_w),
    .cause   (cause_w),
    .mask    (mask_w),
    .cnt     (cnt_w)
);

// File: tb/tri_timer_wdt_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected values and the monitor task
// pops each one, samples the DUT, and compares.
module tri_timer_wdt_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        tick_25m = 1'b0;
    logic        irq, rst_out;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        int          kind;   // 0 register read, 1 irq pin, 2 rst_out pin
        logic [7:0]  a;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    tri_timer_wdt u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tick_25m(tick_25m), .irq(irq), .rst_out(rst_out)
    );

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic exp_reg(input logic [7:0] a, input logic [31:0] e, input string t);
        item_t it;
        it.kind = 0; it.a = a; it.exp = e; it.tag = t;
        sb.push_back(it);
    endtask

    task automatic exp_pin(input int k, input logic e, input string t);
        item_t it;
        it.kind = k; it.a = '0; it.exp = {31'b0, e}; it.tag = t;
        sb.push_back(it);
    endtask

    // Monitor: pop each expected item, sample the DUT, compare.
    task automatic settle();
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            if (it.kind == 0) begin
                addr = it.a;
                #0.2;
                act = rdata;
            end else begin
                #0.2;
                act = (it.kind == 1) ? {31'b0, irq} : {31'b0, rst_out};
            end
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL WATCHDOG: actual=hung expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R12 reset state
        exp_reg(8'h00, 0, "R12 ctrl after reset");
        exp_reg(8'h10, 0, "R12 val0 after reset");
        exp_reg(8'h30, 0, "R12 cause after reset");
        exp_pin(1, 1'b0, "R12 irq after reset");
        exp_pin(2, 1'b0, "R12 rst_out after reset");
        settle();

        // R1 live readback; R8 hold when stopped
        wr(8'h14, 32'h0000_0002);
        wr(8'h1C, 32'hCAFE_0001);
        wr(8'h18, 32'd100);
        wr(8'h00, 32'h10);
        idle(10);
        exp_reg(8'h18, 32'd90, "R1 live count ch1");
        exp_reg(8'h1C, 32'hCAFE_0001, "R1 reload readback ch1");
        settle();
        wr(8'h00, 32'h0);
        idle(5);
        exp_reg(8'h18, 32'd89, "R8 count held when stopped");
        settle();

        // R3 auto-reload on ch0 (value 3, reload 2)
        wr(8'h10, 32'd3);
        wr(8'h00, 32'h3);
        idle(4);
        exp_reg(8'h30, 32'h1, "R3 cause after auto expiry");
        exp_reg(8'h10, 32'd2, "R3 reloaded count");
        settle();
        idle(2);
        exp_reg(8'h10, 32'd0, "R3 counting after reload");
        settle();
        wr(8'h00, 32'h0);

        // R7 mask and R9 clear semantics
        exp_pin(1, 1'b0, "R7 irq masked");
        settle();
        wr(8'h34, 32'h1);
        exp_pin(1, 1'b1, "R7 irq unmasked");
        settle();
        wr(8'h30, 32'hFFFF_FFFF);
        exp_reg(8'h30, 32'h1, "R9 writing one keeps cause");
        settle();
        wr(8'h30, 32'hFFFF_FFFE);
        exp_reg(8'h30, 32'h0, "R9 writing zero clears cause");
        exp_pin(1, 1'b0, "R7 irq drops with cause");
        settle();

        // R3 one-shot on ch1
        wr(8'h18, 32'd2);
        wr(8'h00, 32'h10);
        idle(3);
        exp_reg(8'h30, 32'h2, "R3 one-shot expiry");
        exp_reg(8'h18, 32'd0, "R3 one-shot at zero");
        settle();
        wr(8'h30, 32'h0);
        idle(6);
        exp_reg(8'h30, 32'h0, "R3 one-shot fires once");
        exp_reg(8'h18, 32'd0, "R3 one-shot holds zero");
        settle();
        wr(8'h00, 32'h0);

        // R4 wrap to all-ones reload
        wr(8'h10, 32'd0);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h00, 32'h3);
        idle(2);
        exp_reg(8'h10, 32'hFFFF_FFFE, "R4 wrap then decrement");
        settle();
        wr(8'h00, 32'h0);
        wr(8'h30, 32'h0);

        // R6 reference select on ch1
        wr(8'h18, 32'd50);
        wr(8'h00, 32'h50);
        idle(5);
        exp_reg(8'h18, 32'd50, "R6 no step without tick");
        settle();
        @(negedge clk);
        tick_25m = 1'b1;
        repeat (3) @(posedge clk);
        #1 tick_25m = 1'b0;
        exp_reg(8'h18, 32'd47, "R6 steps on tick");
        settle();
        wr(8'h00, 32'h0);

        // R10 expiry beats clear: zero count, zero reload expires each step
        wr(8'h10, 32'd0);
        wr(8'h14, 32'd0);
        wr(8'h00, 32'h3);
        idle(2);
        wr(8'h30, 32'h0);
        exp_reg(8'h30, 32'h1, "R10 expiry wins over clear");
        settle();
        wr(8'h00, 32'h0);
        wr(8'h30, 32'h0);
        exp_reg(8'h30, 32'h0, "R10 clear once stopped");
        settle();

        // R2 control layout and R12 unmapped offsets
        wr(8'h00, 32'hFFFF_FFFF);
        exp_reg(8'h00, 32'h0000_0777, "R2 control bit layout");
        settle();
        wr(8'h00, 32'h0);
        wr(8'h30, 32'h0);
        wr(8'h3C, 32'hFFFF_FFFF);
        exp_reg(8'h3C, 32'h0, "R12 unmapped reads zero");
        exp_reg(8'h0C, 32'h0, "R12 unmapped gap reads zero");
        settle();

        // R5 watchdog gating, R11 stickiness
        wr(8'h28, 32'd2);
        wr(8'h20, 32'd2);
        wr(8'h00, 32'h100);
        idle(3);
        exp_reg(8'h30, 32'h4, "R5 watchdog cause set");
        exp_pin(2, 1'b0, "R5 no reset while gated off");
        settle();
        wr(8'h38, 32'h1);
        wr(8'h20, 32'd1);
        idle(3);
        exp_pin(2, 1'b1, "R5 reset when enabled");
        exp_pin(1, 1'b0, "R7 watchdog cause masked");
        settle();
        wr(8'h00, 32'h0);
        wr(8'h38, 32'h0);
        idle(3);
        exp_pin(2, 1'b1, "R11 reset output sticky");
        settle();

        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        exp_pin(2, 1'b0, "R11 rst_n clears reset output");
        exp_reg(8'h20, 32'h0, "R12 count zero after reset");
        exp_reg(8'h34, 32'h0, "R12 mask zero after reset");
        exp_reg(8'h38, 32'h0, "R12 reset-enable zero after reset");
        settle();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule